// File: doc/BRIEF.md
# Decoder Clock Source Selector with External-Clock Fallback

This block picks the clock that drives a video decoder from four candidates: a crystal oscillator, a PLL, an external clock arriving on a pin, or that external clock inverted. It also picks which clock is driven back out on the external clock pin. That pin can carry the decoder clock itself, the crystal, the PLL, or the PLL inverted. Each change of source, whether software asks for it or the block makes it on its own, goes through a glitch-free switch. The old clock is gated off on its own falling edge before the new clock is gated on at its own falling edge.

A presence detector runs on a free-running reference clock and watches the external clock. Suppose the external clock is selected and stops. The decoder then moves to the PLL if the PLL is enabled and awake, and to the crystal otherwise. When the external clock comes back, the decoder returns to the selected external source without software action. The presence result is exported as a status bit whenever an external-clock source is selected.

Top module: `clk_source_select`

## Requirements
- R1: `dec_sel` picks the decoder clock source: 2'b00 crystal, 2'b01 PLL, 2'b10 external clock, 2'b11 inverted external clock. In the inverted case, `dec_clk` is low while `ext_clk` is high.
- R2: `pin_sel` picks `pin_clk`: 2'b00 the decoder clock, 2'b01 crystal, 2'b10 PLL, 2'b11 inverted PLL. In the inverted case, `pin_clk` is low while `pll_clk` is high.
- R3: During and after reset, both selections act as 2'b00 until they are loaded after reset. The decoder runs from the crystal, `pin_clk` follows the decoder clock, and `ext_present` is 0.
- R4: When `dec_sel` is 2'b10 or 2'b11 and the external clock is absent, the decoder runs from the PLL if `pll_en` is 1 and `pll_sleep` is 0. Otherwise it runs from the crystal. This holds whether the dead external clock stopped high or low.
- R5: The external clock is declared absent when 64 reference cycles pass with no rising edge. It is declared present again after 4 rising edges, none of them separated by such a gap.
- R6: When the external clock becomes present again while an external source is still selected, the decoder returns to that selected external source by itself.
- R7: `ext_present` is 1 only when the detector reports the clock present and `dec_sel` selects an external source. It is 0 in the crystal and PLL modes.
- R8: Switching never produces a high or low pulse on `dec_clk` or `pin_clk` shorter than the shorter half-period of the old and new sources.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference clock for control and detection |
| rst | input | 1 | Synchronous active-high reset |
| dec_sel | input | 2 | Decoder clock source selection |
| pin_sel | input | 2 | External pin clock source selection |
| pll_en | input | 1 | PLL enabled indication |
| pll_sleep | input | 1 | PLL asleep indication |
| xtal_clk | input | 1 | Crystal oscillator clock |
| pll_clk | input | 1 | PLL output clock |
| ext_clk | input | 1 | External clock from the pin |
| dec_clk | output | 1 | Clock to the decoder |
| pin_clk | output | 1 | Clock driven onto the external pin |
| ext_present | output | 1 | External clock presence status |

## Verification
The bench gives each clock source a distinct period and identifies the active source by measuring the output period. It tells the inverted sources apart by sampling the output phase while the source is high. It stops the external clock both high and low. A design that failed to mask a dead clock stuck high would leave the decoder frozen high and never reach the fallback. The bench probes the detector just inside and just outside its 64-cycle window and its 4-edge re-acquire count. An off-by-a-few window or edge count, or a missing automatic return, would show as a wrong status or a wrong period. Every edge of both outputs is timed, so a switch that breaks the break-before-make order shows up as a short pulse.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    localparam int NUM_SRC = 4;

    typedef enum logic [1:0] {
        DEC_XTAL    = 2'b00,
        DEC_PLL     = 2'b01,
        DEC_EXT     = 2'b10,
        DEC_EXT_INV = 2'b11
    } dec_src_e;

    typedef enum logic [1:0] {
        PIN_DEC     = 2'b00,
        PIN_XTAL    = 2'b01,
        PIN_PLL     = 2'b10,
        PIN_PLL_INV = 2'b11
    } pin_src_e;

    typedef struct packed {
        logic pll_en;
        logic pll_sleep;
        logic present;
    } fb_cond_t;

    function automatic logic is_ext(dec_src_e s);
        return s[1];
    endfunction

    function automatic dec_src_e resolve_dec(dec_src_e req, fb_cond_t c);
        if (!is_ext(req) || c.present)
            return req;
        else if (c.pll_en && !c.pll_sleep)
            return DEC_PLL;
        else
            return DEC_XTAL;
    endfunction

endpackage

// File: rtl/clk_presence_det.sv
module clk_presence_det #(
    parameter int TIMEOUT_CYC  = 64,
    parameter int RELOCK_EDGES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic watch_clk_i,
    output logic present_o
);
    localparam int IW = $clog2(TIMEOUT_CYC);
    localparam int EW = $clog2(RELOCK_EDGES + 1);
    localparam logic [IW-1:0] IDLE_LAST = IW'(TIMEOUT_CYC - 1);
    localparam logic [EW-1:0] EDGE_LAST = EW'(RELOCK_EDGES - 1);

    logic [2:0]    samp_q;
    logic [IW-1:0] idle_q;
    logic [EW-1:0] edges_q;
    logic          present_q;
    logic          rise;

    assign rise = samp_q[1] & ~samp_q[2];

    always_ff @(posedge clk) begin
        if (rst) samp_q <= '0;
        else     samp_q <= {samp_q[1:0], watch_clk_i};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_q    <= '0;
            edges_q   <= '0;
            present_q <= 1'b0;
        end else if (rise) begin
            idle_q <= '0;
            if (edges_q != EW'(RELOCK_EDGES)) edges_q <= edges_q + 1'b1;
            if (edges_q == EDGE_LAST) present_q <= 1'b1;
        end else if (idle_q == IDLE_LAST) begin
            edges_q   <= '0;
            present_q <= 1'b0;
        end else begin
            idle_q <= idle_q + 1'b1;
        end
    end

    assign present_o = present_q;

    // R5
    present_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(present_q) |-> $past(rise) && $past(edges_q) == EDGE_LAST);

    // R5
    absent_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(present_q) |-> $past(idle_q) == IDLE_LAST && !$past(rise));

endmodule

// File: rtl/clk_fallback_ctrl.sv
module clk_fallback_ctrl
    import clksel_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] dec_sel_i,
    input  logic [1:0] pin_sel_i,
    input  logic       pll_en_i,
    input  logic       pll_sleep_i,
    input  logic       present_i,
    output dec_src_e   dec_pick_o,
    output pin_src_e   pin_pick_o,
    output logic       status_o
);
    dec_src_e sel_q;
    pin_src_e pin_q;
    dec_src_e pick_q;
    logic     status_q;
    fb_cond_t cond;

    assign cond = '{pll_en: pll_en_i, pll_sleep: pll_sleep_i, present: present_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q    <= DEC_XTAL;
            pin_q    <= PIN_DEC;
            pick_q   <= DEC_XTAL;
            status_q <= 1'b0;
        end else begin
            sel_q    <= dec_src_e'(dec_sel_i);
            pin_q    <= pin_src_e'(pin_sel_i);
            pick_q   <= resolve_dec(sel_q, cond);
            status_q <= present_i & is_ext(sel_q);
        end
    end

    assign dec_pick_o = pick_q;
    assign pin_pick_o = pin_q;
    assign status_o   = status_q;

    // R4
    pll_fallback_chk: assert property (@(posedge clk) disable iff (rst)
        (is_ext(sel_q) && !present_i && pll_en_i && !pll_sleep_i) |=> pick_q == DEC_PLL);

    // R4
    xtal_fallback_chk: assert property (@(posedge clk) disable iff (rst)
        (is_ext(sel_q) && !present_i && (!pll_en_i || pll_sleep_i)) |=> pick_q == DEC_XTAL);

    // R6
    ext_return_chk: assert property (@(posedge clk) disable iff (rst)
        (is_ext(sel_q) && present_i) |=> pick_q == $past(sel_q));

    // R7
    status_mode_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status_q) |-> $past(present_i) && is_ext($past(sel_q)));

endmodule

// File: rtl/glitchfree_clk_switch.sv
module glitchfree_clk_switch #(
    parameter int NUM = 4
) (
    input  logic                   ref_clk,
    input  logic                   rst,
    input  logic [NUM-1:0]         src_clk_i,
    input  logic [NUM-1:0]         alive_i,
    input  logic [$clog2(NUM)-1:0] pick_i,
    output logic                   clk_o
);
    localparam int SW = $clog2(NUM);

    logic [NUM-1:0] en_vec;
    logic [NUM-1:0] act;

    assign act = en_vec & alive_i;

    for (genvar i = 0; i < NUM; i++) begin : g_leg
        logic s1_q;
        logic en_q;
        logic want;
        logic others_on;

        assign want      = (pick_i == SW'(i));
        assign others_on = |(act & ~(NUM'(1) << i));

        always_ff @(negedge src_clk_i[i]) begin
            if (rst) begin
                s1_q <= (i == 0);
                en_q <= (i == 0);
            end else begin
                s1_q <= want & ~others_on;
                en_q <= s1_q;
            end
        end

        assign en_vec[i] = en_q;
    end

    assign clk_o = |(src_clk_i & act);

    // R8
    single_leg_chk: assert property (@(posedge ref_clk) disable iff (rst)
        $onehot0(act));

endmodule

// File: rtl/clk_source_select.sv
module clk_source_select
    import clksel_pkg::*;
#(
    parameter int TIMEOUT_CYC  = 64,
    parameter int RELOCK_EDGES = 4
) (
    input  logic       ref_clk,
    input  logic       rst,
    input  logic [1:0] dec_sel,
    input  logic [1:0] pin_sel,
    input  logic       pll_en,
    input  logic       pll_sleep,
    input  logic       xtal_clk,
    input  logic       pll_clk,
    input  logic       ext_clk,
    output logic       dec_clk,
    output logic       pin_clk,
    output logic       ext_present
);
    logic                det_present;
    dec_src_e            dec_pick;
    pin_src_e            pin_pick;
    logic [NUM_SRC-1:0]  dec_srcs;
    logic [NUM_SRC-1:0]  pin_srcs;
    logic [NUM_SRC-1:0]  dec_alive;

    clk_presence_det #(
        .TIMEOUT_CYC (TIMEOUT_CYC),
        .RELOCK_EDGES(RELOCK_EDGES)
    ) u_det (
        .clk        (ref_clk),
        .rst        (rst),
        .watch_clk_i(ext_clk),
        .present_o  (det_present)
    );

    clk_fallback_ctrl u_ctrl (
        .clk        (ref_clk),
        .rst        (rst),
        .dec_sel_i  (dec_sel),
        .pin_sel_i  (pin_sel),
        .pll_en_i   (pll_en),
        .pll_sleep_i(pll_sleep),
        .present_i  (det_present),
        .dec_pick_o (dec_pick),
        .pin_pick_o (pin_pick),
        .status_o   (ext_present)
    );

    // Legs are indexed by the select encodings.
    assign dec_srcs  = {~ext_clk, ext_clk, pll_clk, xtal_clk};
    assign dec_alive = {det_present, det_present, 2'b11};
    assign pin_srcs  = {~pll_clk, pll_clk, xtal_clk, dec_clk};

    glitchfree_clk_switch #(.NUM(NUM_SRC)) u_dec_sw (
        .ref_clk  (ref_clk),
        .rst      (rst),
        .src_clk_i(dec_srcs),
        .alive_i  (dec_alive),
        .pick_i   (dec_pick),
        .clk_o    (dec_clk)
    );

    glitchfree_clk_switch #(.NUM(NUM_SRC)) u_pin_sw (
        .ref_clk  (ref_clk),
        .rst      (rst),
        .src_clk_i(pin_srcs),
        .alive_i  ({NUM_SRC{1'b1}}),
        .pick_i   (pin_pick),
        .clk_o    (pin_clk)
    );

endmodule

// File: tb/clk_source_select_tb.sv
module clk_source_select_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct packed {
        logic [1:0] dsel;
        logic [1:0] psel;
        logic       en;
        logic       slp;
        logic       run;
        logic       st;
        logic [7:0] dper;
        logic [7:0] pper;
    } vec_t;

    // Periods in ns: crystal 28, PLL 16, external 60.
    localparam vec_t VEC [8] = '{
        '{2'b00, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 8'd28, 8'd28},
        '{2'b01, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 8'd16, 8'd28},
        '{2'b10, 2'b10, 1'b1, 1'b0, 1'b1, 1'b1, 8'd60, 8'd16},
        '{2'b11, 2'b11, 1'b1, 1'b0, 1'b1, 1'b1, 8'd60, 8'd16},
        '{2'b10, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 8'd16, 8'd16},
        '{2'b10, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'd28, 8'd28},
        '{2'b11, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 8'd28, 8'd28},
        '{2'b10, 2'b00, 1'b1, 1'b0, 1'b1, 1'b1, 8'd60, 8'd60}
    };

    logic ref_clk = 1'b0, xtal_clk = 1'b0, pll_clk = 1'b0, ext_clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] dec_sel = 2'b11, pin_sel = 2'b11;
    logic pll_en = 1'b0, pll_sleep = 1'b0;
    logic ext_run = 1'b1, ext_idle = 1'b0;
    logic dec_clk, pin_clk, ext_present;

    int checks = 0, errors = 0;
    int viol_dec = 0, viol_pin = 0;
    logic mon_on = 1'b0;
    realtime last_dec = 0, last_pin = 0;

    clk_source_select dut_i (
        .ref_clk(ref_clk), .rst(rst), .dec_sel(dec_sel), .pin_sel(pin_sel),
        .pll_en(pll_en), .pll_sleep(pll_sleep), .xtal_clk(xtal_clk),
        .pll_clk(pll_clk), .ext_clk(ext_clk), .dec_clk(dec_clk),
        .pin_clk(pin_clk), .ext_present(ext_present)
    );

    initial forever #10 ref_clk = ~ref_clk;
    initial forever #14 xtal_clk = ~xtal_clk;
    initial forever #8  pll_clk = ~pll_clk;
    initial forever begin
        #30;
        if (ext_run) ext_clk = ~ext_clk;
        else         ext_clk = ext_idle;
    end

    // Pulse-width monitors for R8 (shortest half-period is 8 ns).
    always @(dec_clk) begin
        if (mon_on && ($realtime - last_dec) < 7.5) viol_dec++;
        last_dec = $realtime;
    end
    always @(pin_clk) begin
        if (mon_on && ($realtime - last_pin) < 7.5) viol_pin++;
        last_pin = $realtime;
    end

    task automatic wait_ref(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    task automatic dec_period(output real p);
        realtime t0;
        @(posedge dec_clk); t0 = $realtime;
        @(posedge dec_clk); p = $realtime - t0;
    endtask

    task automatic pin_period(output real p);
        realtime t0;
        @(posedge pin_clk); t0 = $realtime;
        @(posedge pin_clk); p = $realtime - t0;
    endtask

    task automatic chk_real(input string req, input real act, input real exp);
        checks++;
        if (act < exp - 1.0 || act > exp + 1.0) begin
            errors++;
            $display("FAIL %s: actual %0.2f expected %0.2f", req, act, exp);
        end
    endtask

    task automatic chk_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        real p;
        // R3: reset state, selections forced to 2'b00 while inputs ask 2'b11
        wait_ref(40);
        dec_period(p); chk_real("R3 dec on crystal in reset", p, 28.0);
        pin_period(p); chk_real("R3 pin follows dec in reset", p, 28.0);
        @(negedge ref_clk); chk_bit("R3 status in reset", ext_present, 1'b0);
        rst = 1'b0;
        wait_ref(5);
        mon_on = 1'b1;

        // Table walk: R1, R2, R4, R6, R7
        for (int k = 0; k < 8; k++) begin
            @(negedge ref_clk);
            dec_sel   = VEC[k].dsel;
            pin_sel   = VEC[k].psel;
            pll_en    = VEC[k].en;
            pll_sleep = VEC[k].slp;
            ext_idle  = 1'b0;
            ext_run   = VEC[k].run;
            wait_ref(200);
            dec_period(p); chk_real($sformatf("R1/R4/R6 row %0d dec period", k), p, real'(VEC[k].dper));
            pin_period(p); chk_real($sformatf("R2 row %0d pin period", k), p, real'(VEC[k].pper));
            @(negedge ref_clk);
            chk_bit($sformatf("R7 row %0d status", k), ext_present, VEC[k].st);
        end

        // R5: detector window. External selected, PLL enabled and awake.
        @(negedge ref_clk); ext_run = 1'b0;
        wait_ref(40);
        chk_bit("R5 still present inside window", ext_present, 1'b1);
        wait_ref(60);
        chk_bit("R5 absent after window", ext_present, 1'b0);
        dec_period(p); chk_real("R4 fallback to PLL", p, 16.0);
        @(negedge ref_clk); ext_run = 1'b1;
        repeat (2) @(posedge ext_clk);
        wait_ref(3);
        chk_bit("R5 not present after 2 edges", ext_present, 1'b0);
        repeat (4) @(posedge ext_clk);
        wait_ref(4);
        chk_bit("R5 present after 4 edges", ext_present, 1'b1);
        wait_ref(200);
        dec_period(p); chk_real("R6 automatic return to external", p, 60.0);

        // R1: inverted external source phase
        @(negedge ref_clk); dec_sel = 2'b11;
        wait_ref(200);
        @(posedge ext_clk); #5;
        chk_bit("R1 inverted external low while ext high", dec_clk, 1'b0);
        @(negedge ref_clk); dec_sel = 2'b10;
        wait_ref(200);
        @(posedge ext_clk); #5;
        chk_bit("R1 plain external high while ext high", dec_clk, 1'b1);

        // R2: inverted PLL phase on the pin
        @(negedge ref_clk); pin_sel = 2'b11;
        wait_ref(200);
        @(posedge pll_clk); #2;
        chk_bit("R2 inverted PLL low while PLL high", pin_clk, 1'b0);
        @(negedge ref_clk); pin_sel = 2'b10;
        wait_ref(200);
        @(posedge pll_clk); #2;
        chk_bit("R2 plain PLL high while PLL high", pin_clk, 1'b1);

        // R4: external dies stuck high, PLL disabled -> crystal
        @(negedge ref_clk); pll_en = 1'b0; ext_idle = 1'b1; ext_run = 1'b0;
        wait_ref(300);
        dec_period(p); chk_real("R4 stuck-high fallback to crystal", p, 28.0);
        @(negedge ref_clk); chk_bit("R7 status after loss", ext_present, 1'b0);
        @(negedge ref_clk); ext_run = 1'b1;
        wait_ref(300);
        dec_period(p); chk_real("R6 return after stuck-high loss", p, 60.0);

        // R8: no short pulses anywhere in the run
        checks++;
        if (viol_dec != 0) begin
            errors++;
            $display("FAIL R8 dec_clk short pulses: actual %0d expected 0", viol_dec);
        end
        checks++;
        if (viol_pin != 0) begin
            errors++;
            $display("FAIL R8 pin_clk short pulses: actual %0d expected 0", viol_pin);
        end
        finish_run();
    end

endmodule